// File: doc/BRIEF.md
# Accumulator Round-and-Saturate Unit

This block sits beside the accumulator of a multiply-accumulate datapath and turns the wide accumulator value into a rounded 16-bit result. It treats the accumulator as a signed integer part (the upper half plus any guard bits above it) and a fraction (the low 16 bits). The fraction decides whether the integer part moves up by one. A fraction of exactly one half is a tie. On a tie the block picks whichever neighbour is even, so repeated rounding carries no systematic bias.

An update strobe loads a dedicated result register. The datapath raises the strobe when a pipelined MAC operation completes its third stage, when a shift finishes, or when software writes the lowest accumulator byte. The accumulator is only read and is never written. The same arithmetic applies whether the surrounding datapath works on fractional or integer data, so there is no mode input. When the saturate-enable pin is high, results that do not fit in signed 16 bits are clamped. When it is low, they wrap to their low 16 bits.

The strobe is a plain valid with no back-pressure. The unit is always ready, and every strobe is taken in the cycle it is seen, with the accumulator value of that same cycle.

Top module: `acc_round_sat`

## Requirements
- R1: When the low 16 accumulator bits are above 0x8000, the result is the upper part (bits 39..16 taken as signed) plus one.
- R2: When the low 16 bits are below 0x8000, the result is the upper part unchanged.
- R3: When the low 16 bits equal 0x8000, the upper part is incremented if bit 16 is 1 and kept if bit 16 is 0.
- R4: With saturate-enable high, a rounded value above +32767 gives 0x7FFF.
- R5: With saturate-enable high, a rounded value below -32768 gives 0x8000.
- R6: With saturate-enable low, the result is the low 16 bits of the rounded value, including when rounding carries 0x7FFF into 0x8000.
- R7: Guard bits 39..32 take part in the range decision: with saturation a nonzero, non-sign-extension guard field clamps, and without saturation it is discarded.
- R8: The result register is 0x0000 after reset. It changes only on the clock edge that samples the strobe high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_i | input | 1 | Update strobe; loads the result register |
| sat_en_i | input | 1 | 1 = clamp to signed 16-bit limits, 0 = wrap |
| acc_i | input | 40 | Accumulator value, 8 guard bits above a 32-bit body |
| rnd_o | output | 16 | Registered rounded result |

## Verification
The bench targets ties on both even and odd upper halves, for positive and for negative values. A design that rounded half up, or that tested the wrong bit for parity, would be off by one on half of these cases. It drives 0x7FFF with a fraction above one half under both saturation settings. A wrong overflow test would clamp when it should wrap, or wrap when it should clamp. Guard-bit patterns that look in range in bits 31..16 alone expose a design that ignores the guard field. Idle cycles with a changing accumulator catch a register that loads without a strobe.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;
  typedef enum logic { DIR_KEEP = 1'b0, DIR_UP = 1'b1 } rnd_dir_e;
  typedef enum logic [1:0] { SAT_NONE = 2'd0, SAT_POS = 2'd1, SAT_NEG = 2'd2 } sat_kind_e;
endpackage

// File: rtl/acc_round_dir.sv
module acc_round_dir
  import acc_round_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              int_lsb_i,
  output rnd_dir_e          dir_o
);
  localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};

  logic above, tie;
  assign above = frac_i > HALF;
  assign tie   = frac_i == HALF;

  always_comb begin
    if (above || (tie && int_lsb_i)) dir_o = DIR_UP;
    else                             dir_o = DIR_KEEP;
  end

  always_comb begin
    // R3
    if (tie && !int_lsb_i) tie_even_chk: assert (dir_o == DIR_KEEP);
    // R2
    if (frac_i < HALF) below_half_chk: assert (dir_o == DIR_KEEP);
  end
endmodule

// File: rtl/acc_round_clamp.sv
module acc_round_clamp
  import acc_round_pkg::*;
#(
  parameter int HI_W  = 24,
  parameter int RES_W = 16
) (
  input  logic [HI_W-1:0]  hi_i,
  input  rnd_dir_e         dir_i,
  input  logic             sat_en_i,
  output logic [RES_W-1:0] res_o,
  output sat_kind_e        kind_o
);
  localparam int SUM_W = HI_W + 1;
  localparam int TOP_W = SUM_W - RES_W + 1;
  localparam logic [RES_W-1:0] MAX_POS = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] MAX_NEG = {1'b1, {(RES_W-1){1'b0}}};

  logic [SUM_W-1:0] sum;
  logic [TOP_W-1:0] top;
  logic             fits;

  assign sum  = {hi_i[HI_W-1], hi_i} + {{HI_W{1'b0}}, (dir_i == DIR_UP)};
  assign top  = sum[SUM_W-1:RES_W-1];
  assign fits = (top == {TOP_W{1'b0}}) || (top == {TOP_W{1'b1}});

  always_comb begin
    if (fits)              kind_o = SAT_NONE;
    else if (sum[SUM_W-1]) kind_o = SAT_NEG;
    else                   kind_o = SAT_POS;
  end

  always_comb begin
    res_o = sum[RES_W-1:0];
    if (sat_en_i && kind_o == SAT_POS) res_o = MAX_POS;
    if (sat_en_i && kind_o == SAT_NEG) res_o = MAX_NEG;
  end

  always_comb begin
    // R6
    if (!sat_en_i) wrap_low_chk: assert (res_o == sum[RES_W-1:0]);
  end
endmodule

// File: rtl/acc_round_sat.sv
module acc_round_sat
  import acc_round_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 16,
  parameter int RES_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             sat_en_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [RES_W-1:0] rnd_o
);
  localparam int HI_W = ACC_W - FRAC_W;

  rnd_dir_e         dir;
  sat_kind_e        kind;
  logic [RES_W-1:0] next_res;

  acc_round_dir #(.FRAC_W(FRAC_W)) u_dir (
    .frac_i   (acc_i[FRAC_W-1:0]),
    .int_lsb_i(acc_i[FRAC_W]),
    .dir_o    (dir)
  );

  acc_round_clamp #(.HI_W(HI_W), .RES_W(RES_W)) u_clamp (
    .hi_i    (acc_i[ACC_W-1:FRAC_W]),
    .dir_i   (dir),
    .sat_en_i(sat_en_i),
    .res_o   (next_res),
    .kind_o  (kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rnd_o <= '0;
    else if (upd_i) rnd_o <= next_res;
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(rnd_o));
  // R4
  sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && sat_en_i && kind == SAT_POS) |=> rnd_o == {1'b0, {(RES_W-1){1'b1}}});
  // R5
  sat_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && sat_en_i && kind == SAT_NEG) |=> rnd_o == {1'b1, {(RES_W-1){1'b0}}});
  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && kind == SAT_NONE && dir == DIR_UP)
      |=> rnd_o == $past(acc_i[FRAC_W+RES_W-1:FRAC_W]) + 1'b1);
endmodule

// File: tb/acc_round_sat_tb.sv
module acc_round_sat_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic        sat = 1'b0;
  logic [39:0] acc = '0;
  logic [15:0] rnd;
  logic [15:0] exp_q;
  int          checks = 0;
  int          errors = 0;
  string       cur_req = "R8";

  always #(CLK_NS/2) clk = ~clk;

  acc_round_sat dut_i (.clk(clk), .rst_n(rst_n), .upd_i(upd), .sat_en_i(sat),
                       .acc_i(acc), .rnd_o(rnd));

  function automatic logic [15:0] ref_round(logic [39:0] a, bit s);
    longint hi, lo, r;
    hi = longint'($signed(a[39:16]));
    lo = longint'(a[15:0]);
    r  = hi;
    if (lo > 32768 || (lo == 32768 && (hi & 1) != 0)) r = hi + 1;
    if (s && r > 32767)  return 16'h7fff;
    if (s && r < -32768) return 16'h8000;
    return r[15:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)   exp_q <= 16'h0000;
    else if (upd) exp_q <= ref_round(acc, sat);
  end

  always @(negedge clk) begin
    checks++;
    if (rnd !== exp_q) begin
      errors++;
      $display("FAIL %s: rnd=%h expected=%h", cur_req, rnd, exp_q);
    end
  end

  task automatic apply(input logic [39:0] a, input bit s, input string req);
    @(negedge clk);
    cur_req = req; acc = a; sat = s; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    checks++;
    if (rnd !== ref_round(a, s)) begin
      errors++;
      $display("FAIL %s directed: rnd=%h expected=%h", req, rnd, ref_round(a, s));
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog: rnd=%h expected=finish", rnd);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rnd !== 16'h0000) begin
      errors++; $display("FAIL R8 reset: rnd=%h expected=0000", rnd);
    end
    rst_n = 1'b1;
    apply(40'h00_1234_8001, 0, "R1");
    apply(40'h00_1234_ffff, 1, "R1");
    apply(40'h00_1234_7fff, 0, "R2");
    apply(40'hff_fffe_0000, 1, "R2");
    apply(40'h00_1234_8000, 0, "R3");
    apply(40'h00_1235_8000, 0, "R3");
    apply(40'hff_ffff_8000, 1, "R3");
    apply(40'hff_fffe_8000, 1, "R3");
    apply(40'h00_7fff_8000, 1, "R4");
    apply(40'h00_7fff_c000, 1, "R4");
    apply(40'hff_7fff_0000, 1, "R5");
    apply(40'hff_8000_0000, 1, "R5");
    apply(40'h00_7fff_8000, 0, "R6");
    apply(40'h00_7fff_c000, 0, "R6");
    apply(40'h01_0000_0000, 1, "R7");
    apply(40'h01_0000_0000, 0, "R7");
    apply(40'hff_7fff_0000, 0, "R7");
    apply(40'h80_0000_0000, 1, "R7");
    apply(40'h00_4321_0000, 0, "R8");
    @(negedge clk);
    cur_req = "R8"; acc = 40'h00_0bad_ffff; sat = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (rnd !== 16'h4321) begin
      errors++; $display("FAIL R8 hold: rnd=%h expected=4321", rnd);
    end
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cur_req = "R1..R7 random";
      acc = {$urandom, $urandom} & 40'hff_ffff_ffff;
      if (i % 3 == 0) acc[39:32] = {8{acc[31]}};
      if (i % 5 == 0) acc[15:0] = 16'h8000;
      sat = $urandom % 2;
      upd = ($urandom % 4) != 0;
    end
    @(negedge clk);
    upd = 1'b0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule